// File: doc/BRIEF.md
# Eight-Line Vectored Interrupt Controller

This block collects eight interrupt request lines, ranks them by fixed priority and presents a single interrupt output to a processor. The processor answers with a one-cycle acknowledge strobe and receives an 8-bit vector in the same cycle. Software programs the block through a byte-wide register interface with two addresses: a command address and a data address. The data address holds the mask register. The command address takes the initialization opener, end-of-interrupt commands and status-select commands, and it returns either the pending or the in-service register when read.

After the opener, up to three data writes are consumed as configuration words: the vector base, the cascade word and the mode word. The cascade word is stored and presented on an output. In a master/slave pair it marks the line where a slave sits, and in a slave it names its own line on the master. The mode word can enable automatic end-of-interrupt. An acknowledge with nothing eligible returns the vector of the lowest-priority line and leaves the in-service state untouched.

Top module: `vint_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, the request and in-service registers are zero, command-address reads return the request register, and `int_out` is low.
- R2: A command write with bit 4 set starts initialization. It clears the in-service register, the status select and the automatic-EOI flag. The next data write is taken as the vector base. Then comes the cascade word, unless opener bit 1 (single) is set. Then comes the mode word, only if opener bit 0 is set. Later data writes go to the mask.
- R3: The acknowledge vector is the vector base plus the winning line number, modulo 256. It is valid in the cycle where `ack` is high.
- R4: The cascade word written during initialization appears unchanged on `casc_word`.
- R5: Line 0 has the highest priority. `int_out` is high exactly when the highest-priority unmasked pending line ranks above every line in service.
- R6: A line in edge mode (its `irq_level` bit is 0) sets its request bit on a rising input. Acknowledging that line clears the bit. A line in level mode has a request bit that follows the input one cycle later.
- R7: Without automatic EOI, an acknowledge with a winner sets that line's in-service bit.
- R8: When bit 1 of the mode word is set, an acknowledge leaves the in-service register unchanged.
- R9: An acknowledge while `int_out` is low returns base+7 and changes neither the in-service nor the request register, even when line 7 is masked.
- R10: The command byte 0x0B makes command-address reads return the in-service register. The command byte 0x0A makes them return the request register.
- R11: The command byte 0x60+n (n from 0 to 7) clears in-service bit n only.
- R12: The command byte 0x20 clears the highest-priority set in-service bit.
- R13: Outside initialization, a data write sets the mask and a data read returns it. A masked line still records its request bit.
- R14: Data writes consumed as configuration words leave the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = command address, 1 = data/mask address |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte for the current address |
| irq_in | input | 8 | Interrupt request inputs |
| irq_level | input | 8 | Per-line level-mode select |
| ack | input | 1 | Interrupt acknowledge strobe |
| ack_vector | output | 8 | Vector returned during acknowledge |
| int_out | output | 1 | Interrupt request to the processor |
| casc_word | output | 8 | Stored cascade word |

## Verification
The main acknowledge path is driven with a single edge request, with a higher-priority request arriving over a line already in service, and with a lower-priority request arriving under one. These cases separate correct priority against the in-service register from plain pending-bit ordering. Spurious acknowledges are taken with all lines masked while a masked request is latched, to show that masking blocks delivery but not recording. A level-mode line is acknowledged and then released, which tells request-follows-input apart from edge-latch behaviour. Re-initialization with automatic EOI, and with the cascade and mode words skipped, shows that the configuration word order is decoded from the opener bits.

// File: rtl/vint_pkg.sv
package vint_pkg;
    localparam int unsigned VINT_LINES = 8;
    localparam int unsigned VINT_IDX_W = $clog2(VINT_LINES);
    localparam int unsigned VINT_BYTE  = 8;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_BASE,
        PH_CASC,
        PH_MODE
    } vint_phase_e;

    typedef struct packed {
        logic [VINT_LINES-1:0] mask;
        logic [VINT_LINES-1:0] irr;
        logic [VINT_LINES-1:0] isr;
        logic [VINT_LINES-1:0] prev;
        logic [VINT_BYTE-1:0]  base;
        logic [VINT_BYTE-1:0]  casc;
        vint_phase_e           phase;
        logic                  need_mode;
        logic                  single;
        logic                  aeoi;
        logic                  rd_isr;
    } vint_state_t;
endpackage

// File: rtl/vint_lowest.sv
module vint_lowest #(
    parameter int unsigned W  = 8,
    parameter int unsigned IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/vint_req.sv
module vint_req #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] irq_in,
    input  logic [W-1:0] level,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] irr_q,
    input  logic [W-1:0] clr,
    output logic [W-1:0] irr_d
);
    for (genvar g = 0; g < W; g++) begin : g_line
        always_comb begin
            if (level[g]) irr_d[g] = irq_in[g];
            else          irr_d[g] = (irr_q[g] & ~clr[g]) | (irq_in[g] & ~prev[g]);
        end
    end
endmodule

// File: rtl/vint_ctrl.sv
module vint_ctrl
    import vint_pkg::*;
#(
    parameter logic [VINT_BYTE-1:0] RST_MASK = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_cs,
    input  logic                  bus_wr,
    input  logic                  bus_addr,
    input  logic [VINT_BYTE-1:0]  bus_wdata,
    output logic [VINT_BYTE-1:0]  bus_rdata,
    input  logic [VINT_LINES-1:0] irq_in,
    input  logic [VINT_LINES-1:0] irq_level,
    input  logic                  ack,
    output logic [VINT_BYTE-1:0]  ack_vector,
    output logic                  int_out,
    output logic [VINT_BYTE-1:0]  casc_word
);
    localparam logic [VINT_IDX_W-1:0] SPUR_LINE = VINT_IDX_W'(VINT_LINES - 1);

    vint_state_t st_q, st_d;

    logic [VINT_LINES-1:0] eligible, ack_clr, irr_next;
    logic                  el_any, is_any;
    logic [VINT_IDX_W-1:0] el_idx, is_idx;

    // signals seen by the bound checker
    logic [VINT_LINES-1:0] isr_vis, irr_vis, mask_vis;
    logic                  aeoi_vis, init_busy;
    logic [VINT_BYTE-1:0]  base_vis;

    assign eligible = st_q.irr & ~st_q.mask;

    vint_lowest #(.W(VINT_LINES)) u_pend (.vec(eligible), .any(el_any), .idx(el_idx));
    vint_lowest #(.W(VINT_LINES)) u_serv (.vec(st_q.isr), .any(is_any), .idx(is_idx));

    assign int_out    = el_any && (!is_any || (el_idx < is_idx));
    assign ack_vector = st_q.base + VINT_BYTE'(int_out ? el_idx : SPUR_LINE);
    assign ack_clr    = (ack && int_out) ? (VINT_LINES'(1) << el_idx) : '0;
    assign bus_rdata  = bus_addr ? st_q.mask : (st_q.rd_isr ? st_q.isr : st_q.irr);
    assign casc_word  = st_q.casc;

    vint_req #(.W(VINT_LINES)) u_req (
        .irq_in (irq_in),
        .level  (irq_level),
        .prev   (st_q.prev),
        .irr_q  (st_q.irr),
        .clr    (ack_clr),
        .irr_d  (irr_next)
    );

    assign isr_vis   = st_q.isr;
    assign irr_vis   = st_q.irr;
    assign mask_vis  = st_q.mask;
    assign aeoi_vis  = st_q.aeoi;
    assign base_vis  = st_q.base;
    assign init_busy = (st_q.phase != PH_IDLE);

    always_comb begin
        st_d      = st_q;
        st_d.prev = irq_in;
        st_d.irr  = irr_next;

        if (ack && int_out && !st_q.aeoi) st_d.isr = st_d.isr | ack_clr;

        if (bus_cs && bus_wr) begin
            if (!bus_addr) begin
                if (bus_wdata[4]) begin
                    st_d.phase     = PH_BASE;
                    st_d.need_mode = bus_wdata[0];
                    st_d.single    = bus_wdata[1];
                    st_d.isr       = '0;
                    st_d.rd_isr    = 1'b0;
                    st_d.aeoi      = 1'b0;
                end else if (bus_wdata[3]) begin
                    if (bus_wdata[1]) st_d.rd_isr = bus_wdata[0];
                end else begin
                    case (bus_wdata[7:5])
                        3'b011: st_d.isr[bus_wdata[VINT_IDX_W-1:0]] = 1'b0;
                        3'b001: if (is_any) st_d.isr[is_idx] = 1'b0;
                        default: ;
                    endcase
                end
            end else begin
                case (st_q.phase)
                    PH_BASE: begin
                        st_d.base = bus_wdata;
                        if (!st_q.single)       st_d.phase = PH_CASC;
                        else if (st_q.need_mode) st_d.phase = PH_MODE;
                        else                     st_d.phase = PH_IDLE;
                    end
                    PH_CASC: begin
                        st_d.casc  = bus_wdata;
                        st_d.phase = st_q.need_mode ? PH_MODE : PH_IDLE;
                    end
                    PH_MODE: begin
                        st_d.aeoi  = bus_wdata[1];
                        st_d.phase = PH_IDLE;
                    end
                    default: st_d.mask = bus_wdata;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.mask      <= RST_MASK;
            st_q.phase     <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/vint_chk.sv
module vint_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_cs,
    input logic       bus_wr,
    input logic       bus_addr,
    input logic [7:0] bus_wdata,
    input logic       ack,
    input logic       int_out,
    input logic [7:0] ack_vector,
    input logic [7:0] base,
    input logic [7:0] isr,
    input logic [7:0] irr,
    input logic [7:0] mask,
    input logic       aeoi,
    input logic       init_busy
);
    // R5
    int_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> |(irr & ~mask));

    // R3
    vector_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (8'(ack_vector - base) < 8'd8));

    // R7
    ack_marks_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_out && !aeoi && !(bus_cs && bus_wr))
        |=> ($countones(isr) == $countones($past(isr)) + 1));

    // R8
    auto_eoi_keeps_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && aeoi && !(bus_cs && bus_wr)) |=> $stable(isr));

    // R9
    spurious_keeps_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !int_out && !(bus_cs && bus_wr)) |=> $stable(isr));

    // R13
    mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && bus_wr && bus_addr && !init_busy) |=> (mask == $past(bus_wdata)));

    // R14
    config_write_keeps_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && bus_wr && bus_addr && init_busy) |=> $stable(mask));
endmodule

bind vint_ctrl vint_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_cs     (bus_cs),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .ack        (ack),
    .int_out    (int_out),
    .ack_vector (ack_vector),
    .base       (base_vis),
    .isr        (isr_vis),
    .irr        (irr_vis),
    .mask       (mask_vis),
    .aeoi       (aeoi_vis),
    .init_busy  (init_busy)
);

// File: tb/vint_ctrl_bench.sv
`timescale 1ns/1ps
module vint_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] irq_in = '0, irq_level = '0;
    logic       ack = 1'b0;
    logic [7:0] ack_vector, casc_word;
    logic       int_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    typedef struct {
        logic [7:0] vec;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    vint_ctrl u_vint_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_level(irq_level), .ack(ack),
        .ack_vector(ack_vector), .int_out(int_out), .casc_word(casc_word)
    );

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_cs = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, input logic [7:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(bus_rdata, exp, tag);
    endtask

    task automatic do_ack(input logic [7:0] exp, input string tag);
        exp_t e;
        e.vec = exp; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // monitor: compares acknowledge vectors against the scoreboard queue
    always @(negedge clk) begin
        #1;
        if (ack) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R3: unexpected acknowledge, got %02h expected none", ack_vector);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(ack_vector, e.vec, e.tag);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        rd(1'b1, 8'hFF, "R1 mask");
        rd(1'b0, 8'h00, "R1 request reg");
        chk({7'd0, int_out}, 8'h00, "R1 int_out");

        // R2 full init: base 0x20, cascade 0x04, mode normal EOI
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h20);
        wr(1'b1, 8'h04);
        wr(1'b1, 8'h01);
        chk(casc_word, 8'h04, "R4 cascade word");
        rd(1'b1, 8'hFF, "R14 mask untouched by config");
        wr(1'b1, 8'h00);
        rd(1'b1, 8'h00, "R13 mask readback");

        // single edge request on line 3
        tick(); irq_in[3] = 1'b1;
        tick(); #1;
        chk({7'd0, int_out}, 8'h01, "R5 int on line 3");
        rd(1'b0, 8'h08, "R6 edge latched");
        do_ack(8'h23, "R3 vector line 3");
        wr(1'b0, 8'h0B);
        rd(1'b0, 8'h08, "R7/R10 in-service line 3");
        wr(1'b0, 8'h0A);
        rd(1'b0, 8'h00, "R6 ack clears edge request");

        // higher priority nests over line 3
        tick(); irq_in[1] = 1'b1;
        tick(); #1;
        chk({7'd0, int_out}, 8'h01, "R5 line 1 outranks service 3");
        do_ack(8'h21, "R3 vector line 1");
        tick(); irq_in[5] = 1'b1;
        tick(); #1;
        chk({7'd0, int_out}, 8'h00, "R5 line 5 blocked by service");
        wr(1'b0, 8'h0B);
        rd(1'b0, 8'h0A, "R7 two lines in service");
        wr(1'b0, 8'h61);
        rd(1'b0, 8'h08, "R11 specific EOI line 1");
        wr(1'b0, 8'h20);
        rd(1'b0, 8'h00, "R12 nonspecific EOI");
        #1 chk({7'd0, int_out}, 8'h01, "R5 line 5 now delivered");
        do_ack(8'h25, "R3 vector line 5");
        wr(1'b0, 8'h65);
        rd(1'b0, 8'h00, "R11 specific EOI line 5");

        // masked request and spurious acknowledge
        wr(1'b1, 8'hFF);
        tick(); irq_in[6] = 1'b1;
        tick(); #1;
        chk({7'd0, int_out}, 8'h00, "R13 masked line no int");
        wr(1'b0, 8'h0A);
        rd(1'b0, 8'h40, "R13 masked request recorded");
        do_ack(8'h27, "R9 spurious vector");
        rd(1'b0, 8'h40, "R9 request unchanged");
        wr(1'b0, 8'h0B);
        rd(1'b0, 8'h00, "R9 in-service unchanged");

        // level mode on line 4
        wr(1'b1, 8'h40);
        irq_level[4] = 1'b1;
        tick(); irq_in[4] = 1'b1;
        tick(); #1;
        chk({7'd0, int_out}, 8'h01, "R6 level request");
        do_ack(8'h24, "R3 vector line 4");
        wr(1'b0, 8'h0A);
        rd(1'b0, 8'h50, "R6 level request held after ack");
        irq_in[4] = 1'b0;
        tick();
        rd(1'b0, 8'h40, "R6 level request follows input");
        wr(1'b0, 8'h64);

        // re-init with automatic EOI
        wr(1'b0, 8'h0B);
        wr(1'b0, 8'h11);
        rd(1'b0, 8'h40, "R2 init restores request select");
        wr(1'b1, 8'h40);
        wr(1'b1, 8'h02);
        wr(1'b1, 8'h03);
        chk(casc_word, 8'h02, "R4 slave cascade word");
        rd(1'b1, 8'h40, "R14 mask kept through init");
        tick(); irq_in[2] = 1'b1;
        tick(); #1;
        chk({7'd0, int_out}, 8'h01, "R5 line 2 pending");
        do_ack(8'h42, "R3 vector line 2 new base");
        wr(1'b0, 8'h0B);
        rd(1'b0, 8'h00, "R8 auto EOI leaves service clear");

        // short init: single, no mode word
        wr(1'b0, 8'h12);
        wr(1'b1, 8'h80);
        wr(1'b1, 8'h55);
        rd(1'b1, 8'h55, "R2 short sequence then mask");
        chk(casc_word, 8'h02, "R2 cascade skipped");
        do_ack(8'h87, "R9 spurious vector new base");

        repeat (2) tick();
        if (exp_q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL R3: got %0d pending vectors expected 0", exp_q.size());
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule